// File: doc/BRIEF.md
# Multichannel Sample Word Serializer

This block turns the parallel 12-bit words of eight converter channels into eight one-bit serial lanes. It runs from a fast clock at twelve times the sample rate, so one bit leaves each lane per fast cycle. Alongside the lanes it produces a bit-clock level that changes on every fast cycle, and a frame-clock level at the sample rate. The receiver therefore sees one data bit per bit-clock edge and one word per frame-clock period.

A sample strobe captures the eight words into a holding register. At the start of each frame the held words move into the serializing register, and the control inputs are latched at the same moment. Those controls are pattern source, bit order, custom pattern and power-down mask. One pattern source drives every lane. It is live data, an alternating deskew pattern, a sync pattern made of a zero half and a one half, or a programmable custom pattern. Words go out LSB first unless MSB-first order is chosen. Samples are straight offset binary, with mid-scale at code 2048, and pass through unchanged.

Top module: `adc_lane_serializer`

## Requirements
- R1: While reset is held, and in the first cycle after it, the slot counter is 0, the frame clock is 1, the bit clock is 0 and all lanes are 0.
- R2: The bit-clock level changes on every fast-clock cycle and equals bit 0 of the slot number.
- R3: The frame clock is 1 for slots 0 to 5 and 0 for slots 6 to 11, with a period of 12 fast cycles. It rises only at slot 0.
- R4: At slot 0 each lane's word is the value of the most recent strobe seen on or before the last edge of the previous frame. A strobe during a frame does not change that frame. Without a new strobe, the last held word is sent again.
- R5: With bit order 0 (the default), slot k carries bit k of the word.
- R6: With bit order 1, slot k carries bit 11-k of the word.
- R7: Pattern select 01 sends the deskew word 0x555, so bit k is 1 when k is even.
- R8: Pattern select 10 sends the sync word 0xFC0, so bits 0 to 5 are 0 and bits 6 to 11 are 1.
- R9: Pattern select 11 sends the custom word. Bit k is custom[k]: bits 3:0 give slots 0 to 3 in LSB order, bits 7:4 give slots 4 to 7, and bits 11:8 give slots 8 to 11. Pattern select 00 sends the sample data.
- R10: Any test pattern drives the same bit on every lane that is not powered down, whatever the sample data is.
- R11: A lane whose power-down mask bit i is 1 drives a constant 0 for the whole frame. The other lanes are unaffected.
- R12: Controls are sampled only on the edge that starts a frame. A change during a frame does not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 12 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; captures smp_data |
| smp_data | input | 96 | Eight 12-bit words; lane i uses bits 12i+11:12i |
| pat_sel | input | 2 | 00 data, 01 deskew, 10 sync, 11 custom |
| msb_first | input | 1 | 0 LSB first, 1 MSB first |
| cust_pat | input | 12 | Custom pattern word |
| pdn_mask | input | 8 | Per-lane power-down, 1 forces the lane to 0 |
| lane_out | output | 8 | Serial data lanes |
| bclk_out | output | 1 | Bit-clock level |
| fclk_out | output | 1 | Frame-clock level |

## Verification
The hardest situation to reach is a change that arrives in the middle of a frame. A new strobe or new control values must wait for the frame boundary, while the frame already going out must stay untouched. The stimulus reaches this in two ways. It strobes garbage at slot 5 and either overrides it at slot 11 or lets it stand. It also writes random controls at slot 3 and restores the intended ones at slot 11. Every slot of the frame is then compared against a model that holds the values latched at the boundary. Frames with no strobe confirm that the held word repeats.

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer #(
  parameter int LANES = 8,
  parameter int WORD  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  input  logic [LANES*WORD-1:0]  smp_data,
  input  logic [1:0]             pat_sel,
  input  logic                   msb_first,
  input  logic [WORD-1:0]        cust_pat,
  input  logic [LANES-1:0]       pdn_mask,
  output logic [LANES-1:0]       lane_out,
  output logic                   bclk_out,
  output logic                   fclk_out
);
  localparam int SW = $clog2(WORD);
  localparam logic [SW-1:0] LAST = SW'(WORD - 1);
  localparam logic [SW-1:0] HALF = SW'(WORD / 2);

  logic [SW-1:0]         slot_q;
  logic                  bclk_q;
  logic [LANES*WORD-1:0] hold_q, cur_q;
  logic [LANES*WORD-1:0] hold_nxt;
  logic [1:0]            pat_q;
  logic                  msb_q;
  logic [WORD-1:0]       cust_q;
  logic [LANES-1:0]      mask_q;
  logic [WORD-1:0]       desk_w, sync_w, pat_w;
  logic [SW-1:0]         idx;
  logic                  frame_end;

  assign frame_end = (slot_q == LAST);
  assign hold_nxt  = smp_valid ? smp_data : hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      bclk_q <= 1'b0;
      hold_q <= '0;
      cur_q  <= '0;
      pat_q  <= 2'b00;
      msb_q  <= 1'b0;
      cust_q <= '0;
      mask_q <= '0;
    end else begin
      bclk_q <= ~bclk_q;
      hold_q <= hold_nxt;
      if (frame_end) begin
        slot_q <= '0;
        cur_q  <= hold_nxt;
        pat_q  <= pat_sel;
        msb_q  <= msb_first;
        cust_q <= cust_pat;
        mask_q <= pdn_mask;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < WORD; k++) begin
      desk_w[k] = (k % 2 == 0);
      sync_w[k] = (k >= WORD / 2);
    end
    case (pat_q)
      2'b01:   pat_w = desk_w;
      2'b10:   pat_w = sync_w;
      default: pat_w = cust_q;
    endcase
  end

  assign idx = msb_q ? (LAST - slot_q) : slot_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WORD-1:0] w;
    assign w = (pat_q == 2'b00) ? cur_q[i*WORD +: WORD] : pat_w;
    assign lane_out[i] = ~mask_q[i] & w[idx];
  end

  assign bclk_out = bclk_q;
  assign fclk_out = (slot_q < HALF);

  p_bclk_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_q == slot_q[0]);
  p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST);
  p_fclk_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fclk_out) |-> slot_q == '0);
  p_load_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> cur_q == $past(hold_nxt));
  p_mid_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(cur_q));
  p_ctl_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q != '0 |-> ($stable(pat_q) && $stable(msb_q) && $stable(cust_q) && $stable(mask_q)));
  p_pat_uniform_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_q != 2'b00 && mask_q == '0) |-> (lane_out == '0 || lane_out == '1));
  p_pdn_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_out & mask_q) == '0);
endmodule

// File: tb/sim_adc_lane_serializer.sv
module sim_adc_lane_serializer;
  localparam int TCLK = 10;
  localparam int L = 8;
  localparam int W = 12;
  localparam int NF = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [L*W-1:0] smp_data = '0;
  logic [1:0] pat_sel = 2'b00;
  logic msb_first = 1'b0;
  logic [W-1:0] cust_pat = '0;
  logic [L-1:0] pdn_mask = '0;
  logic [L-1:0] lane_out;
  logic bclk_out, fclk_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  adc_lane_serializer #(.LANES(L), .WORD(W)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .pat_sel(pat_sel), .msb_first(msb_first), .cust_pat(cust_pat),
    .pdn_mask(pdn_mask), .lane_out(lane_out), .bclk_out(bclk_out),
    .fclk_out(fclk_out));

  always #(TCLK/2) clk = ~clk;

  logic [L*W-1:0] e_hold, e_cur;
  logic [1:0] e_pat;
  logic e_msb;
  logic [W-1:0] e_cust;
  logic [L-1:0] e_mask;
  string e_tag;

  function automatic logic [L-1:0] exp_lanes(input int s);
    logic [L-1:0] r;
    logic [W-1:0] wd;
    int b;
    b = e_msb ? (W - 1 - s) : s;
    for (int i = 0; i < L; i++) begin
      case (e_pat)
        2'b00: wd = e_cur[i*W +: W];
        2'b01: wd = 12'h555;
        2'b10: wd = 12'hFC0;
        default: wd = e_cust;
      endcase
      r[i] = e_mask[i] ? 1'b0 : wd[b];
    end
    return r;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic check_slot(input int s, input string tag);
    cmp("R2 bclk", {31'd0, bclk_out}, {31'd0, s[0]});
    cmp("R3 fclk", {31'd0, fclk_out}, {31'd0, (s < 6)});
    cmp(tag, {24'd0, lane_out}, {24'd0, exp_lanes(s)});
  endtask

  function automatic string base_tag(input logic [1:0] p, input logic m, input logic [L-1:0] k);
    if (k != '0) return "R11 lanes";
    if (p == 2'b01) return "R7,R10 lanes";
    if (p == 2'b10) return "R8,R10 lanes";
    if (p == 2'b11) return "R9,R10 lanes";
    return m ? "R6 lanes" : "R5 lanes";
  endfunction

  function automatic logic [L*W-1:0] rnd_words();
    logic [L*W-1:0] v;
    for (int i = 0; i < L; i++) v[i*W +: W] = W'($urandom);
    return v;
  endfunction

  initial begin
    logic [L*W-1:0] nd;
    logic [1:0] np;
    logic nm;
    logic [W-1:0] nc;
    logic [L-1:0] nk;
    int mode;
    bit glitch, glitch_next;
    string ntag;
    void'($urandom(32'h1F2E3D4C));
    e_hold = '0; e_cur = '0; e_pat = 2'b00; e_msb = 1'b0; e_cust = '0; e_mask = '0;
    e_tag = "R1 lanes";
    glitch_next = 0;
    repeat (3) @(negedge clk);
    cmp("R1 fclk", {31'd0, fclk_out}, 32'd1);
    cmp("R1 bclk", {31'd0, bclk_out}, 32'd0);
    cmp("R1 lanes", {24'd0, lane_out}, 32'd0);
    rst_n = 1'b1;
    for (int f = 0; f < NF; f++) begin
      glitch = glitch_next;
      glitch_next = 0;
      nd = rnd_words(); np = 2'b00; nm = 1'b0; nc = '0; nk = '0; mode = 1;
      case (f + 1)
        1: nd = {L{12'h800}};
        2: nm = 1'b1;
        3: np = 2'b01;
        4: np = 2'b10;
        5: begin np = 2'b11; nc = 12'hA5C; end
        6: nk = 8'hA5;
        7: mode = 0;
        8: mode = 2;
        9: mode = 3;
        10: glitch_next = 1;
        11: begin np = 2'b11; nm = 1'b1; nc = 12'h31E; end
        12: nk = 8'hFF;
        default: begin
          np = 2'($urandom); nm = 1'($urandom); nc = W'($urandom);
          nk = ($urandom % 4 == 0) ? L'($urandom) : '0;
          mode = $urandom % 4;
          glitch_next = ($urandom % 8 == 0);
        end
      endcase
      ntag = (mode != 1) ? "R4 lanes" : base_tag(np, nm, nk);
      for (int s = 0; s < W; s++) begin
        check_slot(s, glitch ? "R12 lanes" : e_tag);
        smp_valid = 1'b0;
        if ((mode == 2 || mode == 3) && s == 5) begin
          smp_data = (mode == 2) ? nd : rnd_words();
          smp_valid = 1'b1;
        end
        if (glitch && s == 3) begin
          pat_sel = 2'($urandom); msb_first = ~e_msb; cust_pat = ~e_cust; pdn_mask = ~e_mask;
        end
        if (s == W - 1) begin
          pat_sel = np; msb_first = nm; cust_pat = nc; pdn_mask = nk;
          if (mode == 1 || mode == 3) begin smp_data = nd; smp_valid = 1'b1; end
        end
        @(negedge clk);
      end
      if (mode != 0) e_hold = nd;
      e_cur = e_hold; e_pat = np; e_msb = nm; e_cust = nc; e_mask = nk;
      e_tag = ntag;
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule